// File: doc/BRIEF.md
# 8-bit Arithmetic-Logic Unit with Status Flags

This block computes one of seven operations on two 8-bit operands in a single combinational pass: add, subtract, bitwise AND, bitwise OR, invert, and logical shifts left and right by a count taken from the second operand. Beside the result it forms eight status bits. These are a shift-range error, three unsigned magnitude comparisons, carry, signed overflow, zero and sign. The status bits are captured in a flag register on the rising clock edge whenever the flag write enable is high.

Two operand-forcing inputs turn the base operations into the common derived ones. Forcing the second operand to zero makes AND a clear and subtract a pass-through. Forcing it to one makes add an increment and subtract a decrement. A carry input extends add so that multi-byte sums can be chained. The result is valid in the same cycle as the inputs. The flags follow one edge later.

Top module: `alu8_flags`

## Requirements
- R1: With op_sel = 000 (add), result = (A + B + carry_in) mod 256, and the captured C flag is the ninth bit of that sum.
- R2: With op_sel = 001 (subtract), result = (A + ~B + 1) mod 256. carry_in is ignored, and C is the raw carry-out of that sum, so C = 1 exactly when A >= B unsigned.
- R3: op_sel = 010 gives A AND B, 011 gives A OR B, and 100 gives NOT A with B ignored. C and V are 0 for all three.
- R4: op_sel = 101 shifts A left and 110 shifts A right, logically, by B positions. Vacated bits are filled with 0 and the result stays 8 bits, so a count of 8 or more gives 0.
- R5: Flag X is set only for the two shift operations, and only when the count B is greater than 8. It is 0 for every other operation.
- R6: b_zero = 1 forces the effective B to 0. Otherwise b_one = 1 forces it to 1. The effective B feeds the operation and the comparisons, which gives pass-through (subtract, b_zero), clear (AND, b_zero), increment (add, b_one) and decrement (subtract, b_one).
- R7: Flags L, E and G are set when A is less than, equal to, or greater than the effective B as unsigned numbers. Exactly one of the three is set after any load.
- R8: V is the two's-complement overflow of add or subtract and is 0 for other operations. Z is set when the result is 0, and N equals result bit 7.
- R9: The flags output holds, from bit 7 down to bit 0: X, L, E, G, C, V, Z, N. It loads on the rising clock edge only when flag_we = 1 and holds its value otherwise.
- R10: A synchronous reset (rst = 1 at a rising edge) clears all eight flag bits.
- R11: op_sel = 111 is unused. It gives result 0, with C, V and X all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register samples on the rising edge |
| rst | input | 1 | Synchronous reset of the flag register, active high |
| a | input | 8 | First operand |
| b | input | 8 | Second operand, also the shift count |
| op_sel | input | 3 | Operation select (000 add, 001 sub, 010 AND, 011 OR, 100 NOT, 101 shift left, 110 shift right) |
| b_zero | input | 1 | Forces the effective second operand to 0 |
| b_one | input | 1 | Forces the effective second operand to 1 when b_zero is low |
| carry_in | input | 1 | Carry added into the add operation |
| flag_we | input | 1 | Flag register load enable |
| result | output | 8 | Combinational operation result |
| flags | output | 8 | Registered flags X, L, E, G, C, V, Z, N (bit 7 to bit 0) |

## Verification
The assertions watch the flag register on every cycle. They check that it holds when the load enable is low, that a reset clears it, and that the three comparison bits are never set together. They also check that the zero bit agrees with the result of the previous cycle, that the shift-error bit can only follow a shift, and that forcing B to zero makes a carry-free add pass A through unchanged. Only the bench can show the arithmetic itself. It compares the sums, differences, carries, signed overflow, shift results at and past the width limit, the derived operations and the unused code against values it computes from the operands.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_AND  = 3'b010,
        OP_OR   = 3'b011,
        OP_NOT  = 3'b100,
        OP_SHL  = 3'b101,
        OP_SHR  = 3'b110,
        OP_NONE = 3'b111
    } alu_op_e;

    // Packed MSB first: x is bit 7, n is bit 0.
    typedef struct packed {
        logic x;   // shift count out of range
        logic l;   // A below B
        logic e;   // A equal to B
        logic g;   // A above B
        logic c;   // adder carry-out
        logic v;   // signed overflow
        logic z;   // zero result
        logic n;   // result sign bit
    } alu_flags_t;

    localparam int FLAG_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu8_operand.sv
`timescale 1ns/1ps
module alu8_operand #(
    parameter int W = 8
) (
    input  logic [W-1:0] b_in,
    input  logic         b_zero,
    input  logic         b_one,
    output logic [W-1:0] b_eff
);

    localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (b_zero) begin
            b_eff = '0;
        end else if (b_one) begin
            b_eff = ONE_W;
        end else begin
            b_eff = b_in;
        end
    end

endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output alu_flags_t   flags_nx
);

    localparam int MSB = W - 1;

    logic [W:0]   sum_d;
    logic [W-1:0] res_d;
    logic         is_shift;
    logic         is_arith;
    logic         count_big;

    always_comb begin
        sum_d     = '0;
        res_d     = '0;
        is_shift  = (op == OP_SHL) || (op == OP_SHR);
        is_arith  = (op == OP_ADD) || (op == OP_SUB);
        count_big = int'(b) > W;

        case (op)
            OP_ADD: begin
                sum_d = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, carry_in};
                res_d = sum_d[W-1:0];
            end
            OP_SUB: begin
                sum_d = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
                res_d = sum_d[W-1:0];
            end
            OP_AND:  res_d = a & b;
            OP_OR:   res_d = a | b;
            OP_NOT:  res_d = ~a;
            OP_SHL:  res_d = a << b;
            OP_SHR:  res_d = a >> b;
            default: res_d = '0;
        endcase

        flags_nx.x = is_shift && count_big;
        flags_nx.l = a < b;
        flags_nx.e = a == b;
        flags_nx.g = a > b;
        flags_nx.c = is_arith && sum_d[W];
        if (op == OP_ADD) begin
            flags_nx.v = (a[MSB] == b[MSB]) && (res_d[MSB] != a[MSB]);
        end else if (op == OP_SUB) begin
            flags_nx.v = (a[MSB] != b[MSB]) && (res_d[MSB] != a[MSB]);
        end else begin
            flags_nx.v = 1'b0;
        end
        flags_nx.z = res_d == '0;
        flags_nx.n = res_d[MSB];

        result = res_d;
    end

endmodule

// File: rtl/alu8_flagreg.sv
`timescale 1ns/1ps
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  alu_flags_t flags_nx,
    output alu_flags_t flags_q
);

    typedef struct packed {
        alu_flags_t flg;
    } fr_state_t;

    fr_state_t state_d;
    fr_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.flg = flags_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q = state_q.flg;

    // R9: without a load the register keeps its value
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(flags_q));

    // R10: a reset edge leaves all flags cleared
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (flags_q == '0));

    // R7: at most one comparison bit at any time
    assert_cmp_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags_q.l, flags_q.e, flags_q.g}));

endmodule

// File: rtl/alu8_flags.sv
`timescale 1ns/1ps
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   op_sel,
    input  logic         b_zero,
    input  logic         b_one,
    input  logic         carry_in,
    input  logic         flag_we,
    output logic [W-1:0] result,
    output logic [FLAG_W-1:0] flags
);

    logic [W-1:0] b_eff;
    alu_flags_t   flags_nx;
    alu_flags_t   flags_q;
    alu_op_e      op;

    assign op = alu_op_e'(op_sel);

    alu8_operand #(.W(W)) u_operand (
        .b_in   (b),
        .b_zero (b_zero),
        .b_one  (b_one),
        .b_eff  (b_eff)
    );

    alu8_core #(.W(W)) u_core (
        .a        (a),
        .b        (b_eff),
        .op       (op),
        .carry_in (carry_in),
        .result   (result),
        .flags_nx (flags_nx)
    );

    alu8_flagreg u_flagreg (
        .clk      (clk),
        .rst      (rst),
        .load     (flag_we),
        .flags_nx (flags_nx),
        .flags_q  (flags_q)
    );

    assign flags = flags_q;

    // R6: forced-zero B with a carry-free add passes A through
    assert_zero_b_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (b_zero && op_sel == 3'b000 && !carry_in) |-> (result == a));

    // R5: shift error only follows a shift operation
    assert_x_only_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel != 3'b101 && op_sel != 3'b110) |=> !flags[7]);

    // R8: zero flag matches the result that was loaded
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flags[1] == ($past(result) == '0)));

endmodule

// File: tb/alu8_flags_test.sv
`timescale 1ns/1ps
module alu8_flags_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a, b;
    logic [2:0]   op_sel;
    logic         b_zero, b_one, carry_in, flag_we;
    logic [W-1:0] result;
    logic [7:0]   flags;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    alu8_flags #(.W(W)) uut (
        .clk(clk), .rst(rst), .a(a), .b(b), .op_sel(op_sel),
        .b_zero(b_zero), .b_one(b_one), .carry_in(carry_in),
        .flag_we(flag_we), .result(result), .flags(flags)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h op=%0d)",
                     req, act, exp, a, b, op_sel);
        end
    endtask

    function automatic void model(input int av, input int bv, input int op,
                                  input int cz, input int co, input int ci,
                                  output int res, output int fl);
        int be, s, x, l, e, g, c, v, z, n;
        be = cz ? 0 : (co ? 1 : bv);
        s = 0; c = 0; v = 0; x = 0;
        case (op)
            0: begin
                s = av + be + ci; res = s & 255; c = (s >> 8) & 1;
                v = (((av >> 7) & 1) == ((be >> 7) & 1)) && (((res >> 7) & 1) != ((av >> 7) & 1));
            end
            1: begin
                s = av + ((~be) & 255) + 1; res = s & 255; c = (s >> 8) & 1;
                v = (((av >> 7) & 1) != ((be >> 7) & 1)) && (((res >> 7) & 1) != ((av >> 7) & 1));
            end
            2: res = av & be;
            3: res = av | be;
            4: res = (~av) & 255;
            5: begin res = (be >= 8) ? 0 : ((av << be) & 255); x = be > 8; end
            6: begin res = (be >= 8) ? 0 : (av >> be); x = be > 8; end
            default: res = 0;
        endcase
        l = av < be; e = av == be; g = av > be;
        z = res == 0; n = (res >> 7) & 1;
        fl = (x << 7) | (l << 6) | (e << 5) | (g << 4) | (c << 3) | (v << 2) | (z << 1) | n;
    endfunction

    task automatic run_one(input int av, input int bv, input int op,
                           input int cz, input int co, input int ci);
        int er, ef;
        string tag;
        @(negedge clk);
        a = av[W-1:0]; b = bv[W-1:0]; op_sel = op[2:0];
        b_zero = cz[0]; b_one = co[0]; carry_in = ci[0]; flag_we = 1'b1;
        #1;
        model(av, bv, op, cz, co, ci, er, ef);
        if (cz != 0 || co != 0) tag = "R6";
        else if (op == 0) tag = "R1";
        else if (op == 1) tag = "R2";
        else if (op <= 4) tag = "R3";
        else if (op <= 6) tag = "R4";
        else tag = "R11";
        check(tag, int'(result), er);
        @(posedge clk);
        #1;
        check("R9 flag order", int'(flags), ef);
        check("R5 shift error", int'(flags[7]), (ef >> 7) & 1);
        check("R7 compare", int'(flags[6:4]), (ef >> 4) & 7);
        check((op <= 1) ? "R1/R2 carry" : "R3/R11 carry", int'(flags[3]), (ef >> 3) & 1);
        check("R8 v/z/n", int'(flags[2:0]), ef & 7);
    endtask

    initial begin
        rst = 1'b1; a = '0; b = '0; op_sel = '0;
        b_zero = 1'b0; b_one = 1'b0; carry_in = 1'b0; flag_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset", int'(flags), 0);
        rst = 1'b0;

        // Main sweep: every A, selected B values, every op code, both carries.
        begin
            int bl[12] = '{0, 1, 2, 7, 8, 9, 15, 127, 128, 200, 254, 255};
            for (int ai = 0; ai < 256; ai++)
                for (int bi = 0; bi < 12; bi++)
                    for (int op = 0; op < 8; op++)
                        for (int ci = 0; ci < 2; ci++)
                            run_one(ai, bl[bi], op, 0, 0, ci);
        end

        // Derived operations with forced B.
        for (int ai = 0; ai < 256; ai++)
            for (int op = 0; op < 8; op++) begin
                run_one(ai, (ai * 37 + 11) & 255, op, 1, 0, 0);
                run_one(ai, (ai * 53 + 5) & 255, op, 0, 1, 0);
                run_one(ai, (ai * 19 + 3) & 255, op, 1, 1, 0);
            end

        // R9: flags hold when the load enable is low.
        for (int k = 0; k < 16; k++) begin
            int er, ef;
            run_one(k * 13, 255 - k * 7, k % 8, 0, 0, k % 2);
            model(k * 13, 255 - k * 7, k % 8, 0, 0, k % 2, er, ef);
            @(negedge clk);
            a = 8'(k * 29 + 1); b = 8'(k); op_sel = 3'((k + 3) % 8);
            carry_in = 1'b1; flag_we = 1'b0;
            @(posedge clk);
            #1;
            check("R9 hold", int'(flags), ef);
        end

        // R10: reset in the middle of operation.
        run_one(255, 1, 0, 0, 0, 1);
        @(negedge clk);
        rst = 1'b1; flag_we = 1'b1;
        @(posedge clk);
        #1;
        check("R10 mid-run reset", int'(flags), 0);
        @(negedge clk);
        rst = 1'b0;
        run_one(5, 5, 1, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule